// File: doc/BRIEF.md
# Read/Write Bus Turnaround Scheduler

This block sits between a request source and a memory that shares one bidirectional data bus with its controller. It accepts read and write requests through a valid/ready handshake and turns them into a stream of per-cycle commands: read, write, read-side NOP or write-side NOP. When the bus direction has to flip, it holds the request back and inserts NOP cycles of the proper type. During those cycles the memory and the controller swap which side drives the bus and which side terminates it. Requests of the same direction pass straight through, one per cycle.

The block also gives the controller two strobes that are timed against the command stream. The drive enable is high in the cycle in which the controller puts both write beats on the bus. The termination enable is high in the cycle in which read data comes back, a read-latency number of cycles after the read command.

Four parameters set the NOP counts: the read NOPs before a read that follows a write, the read NOPs after a read before the bus turns, the write NOPs before a write, and the read latency (2 or 3). Each extra NOP moves the memory's low-drive window or termination window by one cycle on its side of the turnaround.

Top module: `tat_scheduler`

## Requirements
- R1: After reset the command output is a write-side NOP (code 01), both strobes are low, and the block stands on the write side. A write request sees ready high. With PRE_RD above 0, a read request sees ready low.
- R2: Command codes are 00 read-side NOP, 01 write-side NOP, 10 read, 11 write. A request accepted on a clock edge (valid and ready both high) appears on the command and address outputs in the next cycle. In every NOP cycle the address output is zero.
- R3: Requests of the same direction as the current bus side are accepted in consecutive cycles and issued with no NOP between them.
- R4: When a write is presented while the block is on the read side, the next POST_RD cycles carry read-side NOPs (default 3, never fewer than 2). The PRE_WR cycles after those carry write-side NOPs (default 3, never fewer than 2). The write is issued in the cycle after that.
- R5: When a read is presented while the block is on the write side, the next PRE_RD cycles carry read-side NOPs (default 1). The read is issued in the cycle after that.
- R6: Ready is low in every cycle in which the block is owed or is starting a turnaround NOP. Ready is high whenever the presented type matches the settled bus side.
- R7: The drive enable is high exactly in the cycle after each write command.
- R8: The termination enable is high exactly RL cycles after each read command (RL is 2 or 3, default 3).
- R9: The drive enable and the termination enable are never high in the same cycle.
- R10: In a cycle with no issued request and no owed turnaround, the command is a NOP of the settled side: 00 after a turn to reads, 01 after a turn to writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request type: 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| cmd_o | output | 2 | Command of this cycle (codes in R2) |
| cmd_addr_o | output | AW | Address of the issued read or write, zero for NOPs |
| drv_en_o | output | 1 | Controller drives write data on the bus |
| term_en_o | output | 1 | Controller enables its own termination for read data |

## Verification
The assertions assume that a request stays unchanged (valid, type and address) while ready is low. The bench meets this by presenting the same request again until it is accepted. They also assume that the parameters pass the elaboration checks: at least two NOPs on each side after a read, and a read latency of 2 or 3. Random stimulus keeps runs of the same type with a bias so that long bursts and frequent turnarounds both occur, and it leaves idle gaps to exercise settled-side NOPs.

// File: rtl/tat_pkg.sv
package tat_pkg;
   typedef enum logic [1:0] {
      CMD_RNOP = 2'b00,
      CMD_WNOP = 2'b01,
      CMD_RD   = 2'b10,
      CMD_WR   = 2'b11
   } tat_cmd_e;

   typedef enum logic [2:0] {
      M_RD_SET = 3'd0,
      M_WR_SET = 3'd1,
      M_R2W_R  = 3'd2,
      M_R2W_W  = 3'd3,
      M_W2R    = 3'd4
   } tat_mode_e;
endpackage

// File: rtl/tat_sequencer.sv
module tat_sequencer
   import tat_pkg::*;
#(
   parameter int AW      = 16,
   parameter int PRE_RD  = 1,
   parameter int POST_RD = 3,
   parameter int PRE_WR  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output tat_cmd_e      cmd_q,
   output logic [AW-1:0] addr_q
);
   localparam int MAXN     = (POST_RD > PRE_WR) ? ((POST_RD > PRE_RD) ? POST_RD : PRE_RD)
                                                : ((PRE_WR > PRE_RD) ? PRE_WR : PRE_RD);
   localparam int CW       = $clog2(MAXN + 1);
   localparam bit W2R_FREE = (PRE_RD == 0);
   localparam int W2R_REM  = (PRE_RD > 1) ? PRE_RD - 1 : 1;
   localparam int R2W_REM  = POST_RD - 1;

   tat_mode_e     mode_q, mode_d;
   logic [CW-1:0] rem_q, rem_d;
   tat_cmd_e      cmd_d;
   logic [AW-1:0] addr_d;

   always_comb begin
      mode_d    = mode_q;
      rem_d     = rem_q;
      cmd_d     = CMD_WNOP;
      addr_d    = '0;
      req_ready = 1'b0;
      case (mode_q)
         M_RD_SET: begin
            cmd_d = CMD_RNOP;
            if (!req_write) begin
               req_ready = 1'b1;
               if (req_valid) begin
                  cmd_d  = CMD_RD;
                  addr_d = req_addr;
               end
            end else if (req_valid) begin
               mode_d = M_R2W_R;
               rem_d  = CW'(R2W_REM);
            end
         end
         M_WR_SET: begin
            cmd_d = CMD_WNOP;
            if (req_write || W2R_FREE) begin
               req_ready = 1'b1;
               if (req_valid) begin
                  cmd_d  = req_write ? CMD_WR : CMD_RD;
                  addr_d = req_addr;
                  if (!req_write) mode_d = M_RD_SET;
               end
            end else if (req_valid) begin
               cmd_d  = CMD_RNOP;
               mode_d = (PRE_RD == 1) ? M_RD_SET : M_W2R;
               rem_d  = CW'(W2R_REM);
            end
         end
         M_R2W_R: begin
            cmd_d = CMD_RNOP;
            if (rem_q == CW'(1)) begin
               mode_d = M_R2W_W;
               rem_d  = CW'(PRE_WR);
            end else begin
               rem_d = rem_q - CW'(1);
            end
         end
         M_R2W_W: begin
            cmd_d = CMD_WNOP;
            if (rem_q == CW'(1)) mode_d = M_WR_SET;
            else                 rem_d  = rem_q - CW'(1);
         end
         M_W2R: begin
            cmd_d = CMD_RNOP;
            if (rem_q == CW'(1)) mode_d = M_RD_SET;
            else                 rem_d  = rem_q - CW'(1);
         end
         default: mode_d = M_WR_SET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_WR_SET;
         rem_q  <= '0;
         cmd_q  <= CMD_WNOP;
         addr_q <= '0;
      end else begin
         mode_q <= mode_d;
         rem_q  <= rem_d;
         cmd_q  <= cmd_d;
         addr_q <= addr_d;
      end
   end

   // R6
   turn_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_R2W_R || mode_q == M_R2W_W || mode_q == M_W2R) |-> !req_ready);

   // R4
   rd_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD) |=> (cmd_q == CMD_RD || cmd_q == CMD_RNOP));

   // R4
   wr_after_wnop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_WR) ##1 (cmd_q == CMD_WR) |-> $past(cmd_q) == CMD_WNOP);

   // R2
   nop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RNOP || cmd_q == CMD_WNOP) |-> addr_q == '0);

   generate
      if (PRE_RD > 0) begin : g_w2r_gap
         // R5
         wr_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_q == CMD_WR) |=> (cmd_q != CMD_RD));
      end
   endgenerate
endmodule

// File: rtl/tat_window.sv
module tat_window
   import tat_pkg::*;
#(
   parameter int RL = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  tat_cmd_e cmd,
   output logic     drv_en,
   output logic     term_en
);
   logic [RL-1:0] rd_pipe;
   logic          drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pipe <= '0;
         drv_q   <= 1'b0;
      end else begin
         rd_pipe <= {rd_pipe[RL-2:0], cmd == CMD_RD};
         drv_q   <= (cmd == CMD_WR);
      end
   end

   assign drv_en  = drv_q;
   assign term_en = rd_pipe[RL-1];

   // R7
   drv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WR) |=> drv_en);

   // R7
   drv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> $past(cmd) == CMD_WR);

   // R8
   term_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD) |-> ##RL term_en);
endmodule

// File: rtl/tat_scheduler.sv
module tat_scheduler
   import tat_pkg::*;
#(
   parameter int AW      = 16,
   parameter int RL      = 3,
   parameter int PRE_RD  = 1,
   parameter int POST_RD = 3,
   parameter int PRE_WR  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic [1:0]    cmd_o,
   output logic [AW-1:0] cmd_addr_o,
   output logic          drv_en_o,
   output logic          term_en_o
);
   generate
      if (RL != 2 && RL != 3) begin : g_bad_rl
         $error("tat_scheduler: RL must be 2 or 3");
      end
      if (POST_RD < 2 || PRE_WR < 2) begin : g_bad_r2w
         $error("tat_scheduler: read-to-write gaps need at least 2 NOPs each");
      end
      if (PRE_RD < 0 || PRE_RD > 7) begin : g_bad_w2r
         $error("tat_scheduler: PRE_RD out of range 0..7");
      end
      if (AW < 1) begin : g_bad_aw
         $error("tat_scheduler: AW must be positive");
      end
   endgenerate

   tat_cmd_e cmd_q;

   tat_sequencer #(
      .AW(AW), .PRE_RD(PRE_RD), .POST_RD(POST_RD), .PRE_WR(PRE_WR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_ready(req_ready), .cmd_q(cmd_q), .addr_q(cmd_addr_o)
   );

   tat_window #(.RL(RL)) u_win (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_q),
      .drv_en(drv_en_o), .term_en(term_en_o)
   );

   assign cmd_o = cmd_q;

   // R9
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_en_o && term_en_o));
endmodule

// File: tb/tb_tat_scheduler.sv
`timescale 1ns/1ps
module tb_tat_scheduler;
   localparam int AW = 16, RL = 3, PRE_RD = 1, POST_RD = 3, PRE_WR = 3;
   localparam logic [1:0] RNOP = 2'b00, WNOP = 2'b01, RD = 2'b10, WR = 2'b11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, drv_en_o, term_en_o;
   logic [1:0] cmd_o;
   logic [AW-1:0] cmd_addr_o;

   always #4 clk = ~clk;

   tat_scheduler #(.AW(AW), .RL(RL), .PRE_RD(PRE_RD), .POST_RD(POST_RD), .PRE_WR(PRE_WR)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .cmd_o(cmd_o),
      .cmd_addr_o(cmd_addr_o), .drv_en_o(drv_en_o), .term_en_o(term_en_o)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int m_side = 1;
   int m_rn = 0, m_wn = 0;
   logic [1:0] hist [0:3];

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit w, input logic [AW-1:0] a, output bit acc);
      bit er;
      logic [1:0] ec;
      logic [AW-1:0] ea;
      string tag;
      req_valid = v; req_write = w; req_addr = a;
      #1;
      er = 0; ea = '0; tag = "R10";
      ec = (m_side == 1) ? WNOP : RNOP;
      if (m_rn > 0) begin
         ec = RNOP; m_rn--; tag = (m_side == 1) ? "R4" : "R5";
      end else if (m_wn > 0) begin
         ec = WNOP; m_wn--; tag = "R4";
      end else if ((m_side == 1 && w) || (m_side == 0 && !w) || (m_side == 1 && !w && PRE_RD == 0)) begin
         er = 1;
         if (v) begin
            ec = w ? WR : RD; ea = a; m_side = w ? 1 : 0;
            tag = (hist[0] == ec) ? "R3" : "R2";
         end
      end else if (v) begin
         ec = RNOP;
         if (m_side == 0) begin
            m_rn = POST_RD - 1; m_wn = PRE_WR; m_side = 1; tag = "R4";
         end else begin
            m_rn = PRE_RD - 1; m_side = 0; tag = "R5";
         end
      end
      chk(req_ready == er, "R6", "req_ready", int'(req_ready), int'(er));
      acc = v && er;
      @(posedge clk);
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = ec;
      @(negedge clk);
      chk(cmd_o == ec, tag, "cmd_o", int'(cmd_o), int'(ec));
      chk(cmd_addr_o == ea, "R2", "cmd_addr_o", int'(cmd_addr_o), int'(ea));
      chk(drv_en_o == (hist[1] == WR), "R7", "drv_en_o", int'(drv_en_o), int'(hist[1] == WR));
      chk(term_en_o == (hist[RL] == RD), "R8", "term_en_o", int'(term_en_o), int'(hist[RL] == RD));
      chk(!(drv_en_o && term_en_o), "R9", "drv&term", int'(drv_en_o && term_en_o), 0);
   endtask

   // Present one request until accepted.
   task automatic push(input bit w, input logic [AW-1:0] a);
      bit acc;
      acc = 0;
      while (!acc) step(1'b1, w, a, acc);
   endtask

   task automatic idle(input int n);
      bit acc;
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, acc);
   endtask

   function automatic bit flip(input int pct);
      return ($urandom_range(0, 99) < pct);
   endfunction

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit acc, pv, pw;
      logic [AW-1:0] pa;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 4; i++) hist[i] = WNOP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(cmd_o == WNOP, "R1", "cmd_o reset", int'(cmd_o), int'(WNOP));
      chk(!drv_en_o && !term_en_o, "R1", "strobes reset", int'({drv_en_o, term_en_o}), 0);
      req_write = 1'b1; #1;
      chk(req_ready == 1'b1, "R1", "ready write side", int'(req_ready), 1);
      req_write = 1'b0; #1;
      chk(req_ready == 1'b0, "R1", "ready read side", int'(req_ready), 0);

      // R3 back-to-back writes, R5 turn to reads, R3 read burst
      push(1'b1, 16'h0101); push(1'b1, 16'h0102); push(1'b1, 16'h0103);
      push(1'b0, 16'h0201); push(1'b0, 16'h0202); push(1'b0, 16'h0203);
      // R4 turn to write directly after a read
      push(1'b1, 16'h0301);
      // R10 idle after a write turn
      idle(3);
      push(1'b0, 16'h0401);
      idle(5);
      push(1'b1, 16'h0501);
      push(1'b0, 16'h0601);
      push(1'b1, 16'h0701);

      // random mix
      pv = 0; pw = 0; pa = '0;
      for (int i = 0; i < 4000; i++) begin
         if (!pv) begin
            pv = flip(75);
            if (flip(25)) pw = ~pw;
            pa = AW'($urandom);
         end
         step(pv, pw, pv ? pa : '0, acc);
         if (acc) pv = 0;
      end
      idle(6);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule